// File: doc/BRIEF.md
# Broadcast Command List Sequencer

This block switches a board between operating states in step with the rest of the system. Every board receives the same broadcast status-change command code. Each board keeps its own set of command lists, and the code selects one of them. The block then plays that list back one instruction per clock. Each instruction drives one write onto a configuration-register port. Because instruction N always lands a fixed number of cycles after the command, every write falls at a known point inside the transaction.

The whole list has to finish before the transaction closes. An end-of-transaction pulse that arrives while the list is still running stops playback and sets a sticky overrun flag. When a list does finish, a one-cycle done strobe carries the command code and the number of writes performed, so the change can be logged like any other event. A command that arrives while a list is running is dropped and counted. The lists are filled through a simple per-entry write port, before they are used.

Top module: `cmd_list_seq`

## Requirements
- R1: A cycle with `ld_en` high stores the entry {`ld_end`, `ld_reg`, `ld_val`} at slot `ld_slot` of list `ld_list`; playback of that list later presents exactly the stored register address and data.
- R2: `cmd_valid` high while idle (`busy` low) accepts the command: `busy` is high in the following cycle and list `cmd_code` is played from slot 0.
- R3: Instruction N of the accepted list is presented with `wr_en` high during the (N+1)-th cycle after the accepting clock edge, so the write is captured at the (N+1)-th rising edge after acceptance.
- R4: The instruction with its end bit set is the last one written, and slot DEPTH-1 ends a list even when no end bit is stored there; `wr_en` is low after the last write.
- R5: In the cycle after the last write, `done` is high for exactly one cycle, with `done_code` equal to the command code and `done_count` equal to the number of writes performed.
- R6: `eot` high while `busy` suppresses the write in that cycle and all later writes of the list. `busy` clears and `overrun` is set in the next cycle, and no `done` pulse is given.
- R7: `overrun` stays high until the next accepted command, and it is low in the first cycle of that command's playback.
- R8: `cmd_valid` while `busy` starts nothing and increments `rej_count`, which saturates at all ones.
- R9: `eot` while idle has no effect on `busy`, `wr_en` or `overrun`.
- R10: After reset, `busy`, `wr_en`, `done`, `overrun` and `rej_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | List entry write strobe |
| ld_list | input | CODE_W | List selected for the entry write |
| ld_slot | input | IDX_W | Slot within the list |
| ld_reg | input | RA_W | Register address of the entry |
| ld_val | input | RD_W | Register data of the entry |
| ld_end | input | 1 | End-of-list mark for the entry |
| cmd_valid | input | 1 | Broadcast status-change command strobe |
| cmd_code | input | CODE_W | Command code, selects the list |
| eot | input | 1 | End-of-transaction pulse |
| busy | output | 1 | A list is being played |
| wr_en | output | 1 | Configuration register write enable |
| wr_reg | output | RA_W | Register address of the write |
| wr_val | output | RD_W | Data of the write |
| done | output | 1 | One-cycle completion strobe |
| done_code | output | CODE_W | Command code of the completed list |
| done_count | output | CNT_W | Number of writes the completed list made |
| overrun | output | 1 | Sticky flag: the transaction ended before the list finished |
| rej_count | output | REJ_W | Saturating count of commands rejected while busy |

## Verification
The case that needs care is an end-of-transaction pulse in the same cycle that presents the final instruction of a list. Here the abort has to win: the write is suppressed, `overrun` rises and `done` stays low. The bench provokes this directly by raising `eot` on the last instruction of a known list, and also on instruction 0. In random runs it aborts at random points, and it judges each cycle against a model that counts the writes it has seen and the writes it expects. A rejected command injected while a list runs is a second overlap, and it is checked through `rej_count` after the list ends.

// File: rtl/cmd_list_seq.sv
module cmd_list_seq #(
  parameter int LISTS = 8,
  parameter int DEPTH = 16,
  parameter int RA_W  = 4,
  parameter int RD_W  = 16,
  parameter int REJ_W = 4,
  localparam int CODE_W = $clog2(LISTS),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [CODE_W-1:0] ld_list,
  input  logic [IDX_W-1:0]  ld_slot,
  input  logic [RA_W-1:0]   ld_reg,
  input  logic [RD_W-1:0]   ld_val,
  input  logic              ld_end,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  logic              eot,
  output logic              busy,
  output logic              wr_en,
  output logic [RA_W-1:0]   wr_reg,
  output logic [RD_W-1:0]   wr_val,
  output logic              done,
  output logic [CODE_W-1:0] done_code,
  output logic [CNT_W-1:0]  done_count,
  output logic              overrun,
  output logic [REJ_W-1:0]  rej_count
);
  localparam int ENT_W = RA_W + RD_W + 1;
  localparam logic [REJ_W-1:0] REJ_MAX = {REJ_W{1'b1}};
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

  logic [ENT_W-1:0]  mem [LISTS][DEPTH];
  logic [CODE_W-1:0] code_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ENT_W-1:0]  cur;
  logic              last;

  always_ff @(posedge clk)
    if (ld_en) mem[ld_list][ld_slot] <= {ld_end, ld_reg, ld_val};

  assign cur    = mem[code_q][idx_q];
  assign last   = cur[ENT_W-1] || (idx_q == IDX_LAST);
  assign wr_en  = busy && !eot;
  assign wr_reg = cur[RD_W +: RA_W];
  assign wr_val = cur[RD_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      code_q     <= '0;
      idx_q      <= '0;
      done       <= 1'b0;
      done_code  <= '0;
      done_count <= '0;
      overrun    <= 1'b0;
      rej_count  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (cmd_valid) begin
          busy    <= 1'b1;
          code_q  <= cmd_code;
          idx_q   <= '0;
          overrun <= 1'b0;
        end
      end else begin
        if (cmd_valid && rej_count != REJ_MAX) rej_count <= rej_count + 1'b1;
        if (eot) begin
          busy    <= 1'b0;
          overrun <= 1'b1;
        end else if (last) begin
          busy       <= 1'b0;
          done       <= 1'b1;
          done_code  <= code_q;
          done_count <= CNT_W'(idx_q) + CNT_W'(1);
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> (busy && !overrun)); // R2
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(wr_en))); // R5
  AST_DONE_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (done_count != '0 && done_count <= CNT_W'(DEPTH))); // R4
  AST_EOT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && eot) |=> (!busy && overrun && !done)); // R6
  AST_OVERRUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(cmd_valid && !busy)) |=> overrun); // R7
  AST_REJ_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid && rej_count != REJ_MAX) |=> rej_count == $past(rej_count) + 1'b1); // R8
  AST_IDLE_EOT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid && eot) |=> (!busy && $stable(overrun))); // R9
endmodule

// File: tb/cmd_list_seq_tb_top.sv
module cmd_list_seq_tb_top;
  localparam int LISTS = 8, DEPTH = 16, RA_W = 4, RD_W = 16, REJ_W = 4;
  localparam int REJ_MAX = (1 << REJ_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_en = 1'b0, ld_end = 1'b0, cmd_valid = 1'b0, eot = 1'b0;
  logic [2:0] ld_list = '0, cmd_code = '0;
  logic [3:0] ld_slot = '0, ld_reg = '0;
  logic [15:0] ld_val = '0;
  logic busy, wr_en, done, overrun;
  logic [3:0] wr_reg;
  logic [15:0] wr_val;
  logic [2:0] done_code;
  logic [4:0] done_count;
  logic [3:0] rej_count;

  cmd_list_seq #(.LISTS(LISTS), .DEPTH(DEPTH), .RA_W(RA_W), .RD_W(RD_W), .REJ_W(REJ_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_list(ld_list), .ld_slot(ld_slot),
    .ld_reg(ld_reg), .ld_val(ld_val), .ld_end(ld_end), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .eot(eot), .busy(busy), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_val(wr_val), .done(done), .done_code(done_code), .done_count(done_count),
    .overrun(overrun), .rej_count(rej_count));

  always #5 clk = ~clk;

  int checks = 0, failures = 0, rej_model = 0;
  int llen [LISTS];
  bit nomark [LISTS];
  logic [3:0] lreg [LISTS][DEPTH];
  logic [15:0] lval [LISTS][DEPTH];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_writes(int c, int ab);
    return (ab >= 0 && ab < llen[c]) ? ab : llen[c];
  endfunction

  function automatic int exp_rej(int r);
    return (r > REJ_MAX) ? REJ_MAX : r;
  endfunction

  // R1: fill list c with len entries, end bit on the last one unless nm
  task automatic load_list(int c, int len, bit nm);
    llen[c] = len;
    nomark[c] = nm;
    for (int s = 0; s < DEPTH; s++) begin
      lreg[c][s] = 4'($urandom);
      lval[c][s] = 16'($urandom);
      ld_en = 1'b1; ld_list = 3'(c); ld_slot = 4'(s);
      ld_reg = lreg[c][s]; ld_val = lval[c][s];
      ld_end = (s == len - 1 && !nm) ? 1'b1 : (s >= len ? 1'($urandom) : 1'b0);
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic run(int c, int ab, bit inj);
    int n = exp_writes(c, ab);
    cmd_valid = 1'b1; cmd_code = 3'(c);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R2 busy", busy, 1);
    chk(overrun == 1'b0, "R7 cleared", overrun, 0);
    for (int i = 0; i < llen[c]; i++) begin
      if (i == ab) begin
        eot = 1'b1; #1;
        chk(wr_en == 1'b0, "R6 write suppressed", wr_en, 0);
        @(negedge clk);
        eot = 1'b0;
        break;
      end
      if (inj && i == 1) begin
        cmd_valid = 1'b1; cmd_code = 3'(c ^ 1);
        rej_model++;
      end
      chk(wr_en == 1'b1, "R3 wr_en", wr_en, 1);
      chk(wr_reg == lreg[c][i], "R1 reg", wr_reg, lreg[c][i]);
      chk(wr_val == lval[c][i], "R1 val", wr_val, lval[c][i]);
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    if (n < llen[c]) begin
      chk(busy == 1'b0, "R6 busy", busy, 0);
      chk(overrun == 1'b1, "R6 overrun", overrun, 1);
      chk(done == 1'b0, "R6 no done", done, 0);
      @(negedge clk);
      chk(overrun == 1'b1, "R7 sticky", overrun, 1);
      chk(wr_en == 1'b0, "R6 no write", wr_en, 0);
    end else begin
      chk(wr_en == 1'b0, "R4 stop", wr_en, 0);
      chk(done == 1'b1, "R5 done", done, 1);
      chk(done_code == 3'(c), "R5 code", done_code, c);
      chk(done_count == 5'(n), "R4 count", done_count, n);
      chk(overrun == 1'b0, "R6 no overrun", overrun, 0);
      @(negedge clk);
      chk(done == 1'b0, "R5 single pulse", done, 0);
    end
    chk(busy == 1'b0, "R2 idle", busy, 0);
    chk(rej_count == 4'(exp_rej(rej_model)), "R8 rej", rej_count, exp_rej(rej_model));
  endtask

  task automatic idle_eot();
    logic ov = overrun;
    eot = 1'b1;
    @(negedge clk);
    eot = 1'b0;
    chk(overrun == ov, "R9 overrun", overrun, ov);
    chk(busy == 1'b0, "R9 busy", busy, 0);
    chk(wr_en == 1'b0, "R9 wr_en", wr_en, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R10 busy", busy, 0);
    chk(wr_en == 1'b0, "R10 wr_en", wr_en, 0);
    chk(done == 1'b0, "R10 done", done, 0);
    chk(overrun == 1'b0, "R10 overrun", overrun, 0);
    chk(rej_count == 4'd0, "R10 rej", rej_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    load_list(0, 1, 1'b0);
    load_list(1, 16, 1'b1);
    load_list(2, 5, 1'b0);
    load_list(3, 16, 1'b0);
    for (int c = 4; c < LISTS; c++) load_list(c, 1 + int'($urandom % 16), 1'b0);
    run(0, -1, 1'b0);
    run(1, -1, 1'b1);
    run(2, 4, 1'b0);       // eot on final instruction: abort wins
    idle_eot();
    run(3, 0, 1'b0);
    run(3, -1, 1'b1);
    idle_eot();
    for (int k = 0; k < 60; k++) begin
      int c = int'($urandom % LISTS);
      int ab = ($urandom % 4 == 0) ? int'($urandom % 16) : -1;
      if (k % 15 == 14) begin
        int len = 1 + int'($urandom % 16);
        load_list(c, len, (len == 16) && 1'($urandom));
      end
      run(c, ab, 1'($urandom));
      if ($urandom % 5 == 0) idle_eot();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule